// File: doc/BRIEF.md
# Master clock source selector

This block produces the master clock enable for a design built around one fast reference clock. There are three candidate sources, each arriving as a one-cycle strobe on the reference clock: a slow clock, the main oscillator clock and a PLL clock. One write to a 5-bit configuration port chooses the source and a power-of-two prescaler. The block emits one enable pulse for every 2^N strobes of the chosen source.

A ready flag tells the surrounding logic whether the enable comes from the programmed setting. Any write that changes the stored setting restarts the divider and drops the flag. The flag returns once the new source has produced two strobes, and no enable pulse is issued during that settle window. While the PLL is selected but not locked, the block runs from the main clock with the same prescaler and keeps the flag low. When lock returns, the block settles onto the PLL again and raises the flag.

Top module: `mck_clock_sel`

## Requirements
- R1: A single write on `cfg_we` loads the whole setting: `cfg_wdata[1:0]` is the source code and `cfg_wdata[4:2]` is the prescale exponent N. Value 0x11 selects the main clock divided by 16.
- R2: A write whose value differs from the stored setting makes `mck_rdy` read 0 in the cycle after the write.
- R3: After a restart, `mck_rdy` stays low until exactly two strobes of the new effective source have been seen, and it reads 1 in the cycle after the second one. `mck_en` stays low throughout that window.
- R4: Once settled, `mck_en` pulses for one cycle per 2^N strobes of the effective source, for N = 0 to 6, giving divide by 1, 2, 4, 8, 16, 32 and 64. Each pulse comes one cycle after the strobe that completes the count. Counting starts from zero when the settle window ends.
- R5: Source code 00 selects the slow strobe, 01 the main strobe and 11 the PLL strobe. Reserved code 10 behaves exactly like 00.
- R6: Reserved exponent code 7 behaves as divide by 1.
- R7: While code 11 is stored and `pll_lock` is low (sampled through one register), `mck_rdy` is 0 and `mck_en` follows the main strobe at the programmed ratio. Entering this state restarts the block, and it settles on two main strobes.
- R8: When `pll_lock` returns high with code 11 stored, the block restarts on the PLL strobe. `mck_rdy` rises after two PLL strobes, and the enable then follows the PLL strobe.
- R9: A write of the value already stored has no effect: `mck_rdy` stays high and the divider keeps counting.
- R10: After reset the setting is slow source, divide by 1, and `mck_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Setting: [4:2] prescale exponent, [1:0] source code |
| slow_stb | input | 1 | One-cycle strobe per slow clock period |
| main_stb | input | 1 | One-cycle strobe per main clock period |
| pll_stb | input | 1 | One-cycle strobe per PLL clock period |
| pll_lock | input | 1 | PLL lock indication |
| mck_en | output | 1 | Master clock enable pulse |
| mck_rdy | output | 1 | High when the enable runs from the programmed setting |

## Verification
The bench writes all 31 non-reset setting codes in turn. After each write it counts the strobes of the expected source up to the rise of the ready flag, then counts the strobes between enable pulses, so a design that counts the wrong source or restarts at the wrong point would show a wrong strobe count. Codes with reserved fields are held to the same counts as their legal twins, so decoding code 10 or exponent 7 as anything else would be reported. Lock is dropped and restored under a PLL setting, and the PLL is also selected while unlocked. Missing the fallback, raising ready too early, or not settling on the PLL again shows up as a wrong flag level or as pulses spaced by the wrong strobe. A rewrite of the stored value checks that no spurious restart pulls the flag low.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int SRC_W = 2;
  localparam int EXP_W = 3;
  localparam int CFG_W = SRC_W + EXP_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_RSVD = 2'b10,
    SRC_PLL  = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    src_sel_e         src;
  } mck_cfg_t;

  localparam mck_cfg_t CFG_RESET = '{exp: '0, src: SRC_SLOW};
endpackage

// File: rtl/mck_cfg_reg.sv
module mck_cfg_reg
  import mck_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  mck_cfg_t cfg_wdata,
  input  logic     pll_lock,
  output mck_cfg_t cfg_q,
  output logic     lock_q,
  output logic     restart
);
  mck_cfg_t cfg_d;
  logic     wr_change;
  logic     lock_evt;

  always_comb begin
    wr_change = cfg_we && (cfg_wdata != cfg_q);
    lock_evt  = (cfg_q.src == SRC_PLL) && (pll_lock != lock_q);
    restart   = wr_change || lock_evt;
    cfg_d     = wr_change ? cfg_wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      lock_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= pll_lock;
    end
  end
endmodule

// File: rtl/mck_src_mux.sv
module mck_src_mux
  import mck_pkg::*;
(
  input  src_sel_e src,
  input  logic     lock_q,
  input  logic     slow_stb,
  input  logic     main_stb,
  input  logic     pll_stb,
  output logic     src_stb,
  output logic     fallback
);
  always_comb begin
    fallback = (src == SRC_PLL) && !lock_q;
    unique case (src)
      SRC_MAIN: src_stb = main_stb;
      SRC_PLL:  src_stb = lock_q ? pll_stb : main_stb;
      default:  src_stb = slow_stb;
    endcase
  end
endmodule

// File: rtl/mck_settle.sv
module mck_settle #(
  parameter int SETTLE_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic src_stb,
  output logic settling
);
  localparam int SCNT_W = (SETTLE_N > 1) ? $clog2(SETTLE_N) : 1;

  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic              settling_q, settling_d;

  always_comb begin
    scnt_d     = scnt_q;
    settling_d = settling_q;
    if (restart) begin
      scnt_d     = '0;
      settling_d = 1'b1;
    end else if (settling_q && src_stb) begin
      if (scnt_q == SCNT_W'(SETTLE_N - 1)) begin
        scnt_d     = '0;
        settling_d = 1'b0;
      end else begin
        scnt_d = scnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q     <= '0;
      settling_q <= 1'b0;
    end else begin
      scnt_q     <= scnt_d;
      settling_q <= settling_d;
    end
  end

  assign settling = settling_q;
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler #(
  parameter int EXP_MAX = 6,
  parameter int EXP_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_code,
  input  logic             restart,
  input  logic             hold,
  input  logic             src_stb,
  output logic             div_en
);
  localparam int CNT_W = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [EXP_W-1:0] eff_exp;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;

  always_comb begin
    eff_exp = (exp_code > EXP_W'(EXP_MAX)) ? '0 : exp_code;
    lim     = {CNT_W{1'b1}} >> (EXP_W'(CNT_W) - eff_exp);
  end

  always_comb begin
    cnt_d = cnt_q;
    en_d  = 1'b0;
    if (restart || hold) begin
      cnt_d = '0;
    end else if (src_stb) begin
      if (cnt_q == lim) begin
        cnt_d = '0;
        en_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign div_en = en_q;
endmodule

// File: rtl/mck_clock_sel.sv
module mck_clock_sel
  import mck_pkg::*;
#(
  parameter int EXP_MAX    = 6,
  parameter int SETTLE_N   = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             slow_stb,
  input  logic             main_stb,
  input  logic             pll_stb,
  input  logic             pll_lock,
  output logic             mck_en,
  output logic             mck_rdy
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  generate
    for (genvar g = 0; g < RST_STAGES; g++) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[g] <= 1'b0;
        else        rst_pipe[g] <= (g == 0) ? 1'b1 : rst_pipe[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  mck_cfg_t wdata_s;
  mck_cfg_t cfg_q;
  logic     lock_q;
  logic     restart;
  logic     src_stb;
  logic     fallback;
  logic     settling;

  assign wdata_s = mck_cfg_t'(cfg_wdata);

  mck_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(wdata_s),
    .pll_lock (pll_lock),
    .cfg_q    (cfg_q),
    .lock_q   (lock_q),
    .restart  (restart)
  );

  mck_src_mux u_mux (
    .src     (cfg_q.src),
    .lock_q  (lock_q),
    .slow_stb(slow_stb),
    .main_stb(main_stb),
    .pll_stb (pll_stb),
    .src_stb (src_stb),
    .fallback(fallback)
  );

  mck_settle #(.SETTLE_N(SETTLE_N)) u_settle (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart),
    .src_stb (src_stb),
    .settling(settling)
  );

  mck_prescaler #(.EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .exp_code(cfg_q.exp),
    .restart (restart),
    .hold    (settling),
    .src_stb (src_stb),
    .div_en  (mck_en)
  );

  assign mck_rdy = !settling && !fallback;
endmodule

// File: rtl/mck_clock_sel_chk.sv
module mck_clock_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [4:0] cfg_wdata,
  input logic [4:0] cfg_q,
  input logic       lock_q,
  input logic       pll_lock,
  input logic       src_stb,
  input logic       mck_en,
  input logic       mck_rdy
);
  a_r2_rdy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata != cfg_q)) |=> !mck_rdy);

  a_r9_same_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata == cfg_q) && mck_rdy &&
     !((cfg_q[1:0] == 2'b11) && (pll_lock != lock_q))) |=> mck_rdy);

  a_r7_fallback_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q[1:0] == 2'b11) && !lock_q) |-> !mck_rdy);

  a_r4_en_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mck_en |-> $past(src_stb));

  a_r3_en_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    mck_en |-> (mck_rdy || ((cfg_q[1:0] == 2'b11) && !lock_q)));
endmodule

bind mck_clock_sel mck_clock_sel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_q    (cfg_q),
  .lock_q   (lock_q),
  .pll_lock (pll_lock),
  .src_stb  (src_stb),
  .mck_en   (mck_en),
  .mck_rdy  (mck_rdy)
);

// File: tb/mck_clock_sel_tb.sv
module mck_clock_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_P = 11;
  localparam int MAIN_P = 3;
  localparam int PLL_P  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       slow_stb = 1'b0;
  logic       main_stb = 1'b0;
  logic       pll_stb = 1'b0;
  logic       pll_lock = 1'b1;
  logic       mck_en;
  logic       mck_rdy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mck_clock_sel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .slow_stb(slow_stb), .main_stb(main_stb), .pll_stb(pll_stb),
    .pll_lock(pll_lock), .mck_en(mck_en), .mck_rdy(mck_rdy)
  );

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      slow_stb = (cyc % SLOW_P) == 3;
      main_stb = (cyc % MAIN_P) == 1;
      pll_stb  = (cyc % PLL_P) == 0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // 0 slow, 1 main, 2 pll
  function automatic bit stb_of(input int src);
    case (src)
      1:       return main_stb;
      2:       return pll_stb;
      default: return slow_stb;
    endcase
  endfunction

  task automatic write_cfg(input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // counts strobes of src until ready, expects exactly two and no enable
  task automatic wait_ready(input int src, input string tag);
    int n = 0;
    int en_seen = 0;
    int guard = 0;
    while (!mck_rdy && guard < 5000) begin
      if (mck_en) en_seen++;
      if (stb_of(src)) n++;
      @(negedge clk);
      guard++;
    end
    check(mck_rdy === 1'b1, tag, "ready reached", int'(mck_rdy), 1);
    check(n == 2, tag, "strobes before ready", n, 2);
    check(en_seen == 0, tag, "enable pulses while settling", en_seen, 0);
  endtask

  task automatic measure(input int src, input int div, input int offset,
                         input int npulse, input bit exp_rdy, input string tag);
    int n = 0;
    int got = 0;
    int guard = 0;
    int rdy_bad = 0;
    while (got < npulse && guard < 20000) begin
      if (mck_rdy !== exp_rdy) rdy_bad++;
      if (mck_en) begin
        check(n == ((got == 0) ? offset + div : div), tag, "strobes per pulse",
              n, (got == 0) ? offset + div : div);
        n = 0;
        got++;
      end
      if (stb_of(src)) n++;
      @(negedge clk);
      guard++;
    end
    check(got == npulse, tag, "pulses seen", got, npulse);
    check(rdy_bad == 0, tag, "ready level during run", rdy_bad, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 190000, 0);
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state slow /1 ready high
    check(mck_rdy === 1'b1, "R10", "ready after reset", int'(mck_rdy), 1);
    measure(0, 1, 0, 3, 1'b1, "R10");

    // sweep all codes with lock held high
    for (int c = 1; c < 32; c++) begin
      logic [4:0] code;
      int src;
      int e;
      int div;
      string tag;
      code = 5'(c);
      src = (code[1:0] == 2'b01) ? 1 : (code[1:0] == 2'b11) ? 2 : 0;
      e = int'(code[4:2]);
      div = (e >= 7) ? 1 : (1 << e);
      if (code[1:0] == 2'b10) tag = "R5";
      else if (e == 7)        tag = "R6";
      else if (code == 5'h11) tag = "R1";
      else                    tag = "R4";
      write_cfg(code);
      check(mck_rdy === 1'b0, "R2", "ready after changing write", int'(mck_rdy), 0);
      wait_ready(src, "R3");
      measure(src, div, 0, 3, 1'b1, tag);
    end

    // R9: rewrite the same value
    write_cfg(5'h1F);
    check(mck_rdy === 1'b1, "R9", "ready after same write", int'(mck_rdy), 1);
    measure(2, 1, 0, 2, 1'b1, "R9");

    // PLL /2, then lose lock
    write_cfg(5'h07);
    wait_ready(2, "R3");
    measure(2, 2, 0, 2, 1'b1, "R4");
    @(negedge clk);
    pll_lock = 1'b0;
    @(negedge clk);
    check(mck_rdy === 1'b0, "R7", "ready after lock loss", int'(mck_rdy), 0);
    measure(1, 2, 2, 3, 1'b0, "R7");

    // lock returns
    pll_lock = 1'b1;
    @(negedge clk);
    check(mck_rdy === 1'b0, "R8", "ready right after relock", int'(mck_rdy), 0);
    wait_ready(2, "R8");
    measure(2, 2, 0, 3, 1'b1, "R8");

    // select PLL /4 while unlocked
    pll_lock = 1'b0;
    write_cfg(5'h0B);
    check(mck_rdy === 1'b0, "R7", "ready with unlocked PLL", int'(mck_rdy), 0);
    measure(1, 4, 2, 3, 1'b0, "R7");
    pll_lock = 1'b1;

    // reset again from a non-default setting
    do_reset();
    check(mck_rdy === 1'b1, "R10", "ready after second reset", int'(mck_rdy), 1);
    measure(0, 1, 0, 2, 1'b1, "R10");

    summary();
    $finish;
  end
endmodule